// File: doc/BRIEF.md
# Memory Test Per-Bit Result Checker

This block sits at the read-return side of a memory test harness. Each cycle in which the memory returns a read beat, it compares the wide local read word against the word the traffic source expected. It drives one pass-not-fail flag per data bit in two forms. The live form shows the result of the most recent beat. The sticky form remembers whether that bit has ever miscompared since reset. The flags let a logic analyser or a status path find which data line and which burst beat failed.

The block also gives three overall verdicts for a test run made of repeated loops. The fail verdict is raised by any miscompare, however many loops have completed. The pass verdict is raised once a configured number of loops has completed with no error, and only when the run is finite. The timeout verdict is raised when read traffic stops arriving for too long before the run has passed.

The wide word is a whole burst folded together with the first beat in the lowest bits. Flag index = beat × MEM_W + lane, so flag k always belongs to read-data bit k.

Top module: `pnf_result_checker`

## Requirements
- R1: The block has MEM_W × BEATS flags of each kind (256 with the defaults 32 and 8). Flag k belongs to bit k of the read word: beat k / MEM_W (beat 0 in bits MEM_W-1:0) and lane k % MEM_W. For example, flag 64 is lane 0 of the third beat.
- R2: One cycle after a cycle with `rd_valid` high, each live flag is 1 if its read bit equals its expected bit and 0 otherwise. A flag that went low returns high on the next cycle whose beat matches or carries no valid data.
- R3: One cycle after a cycle with `rd_valid` low, every live flag is 1, whatever the data inputs carry.
- R4: Each sticky flag is the AND of every live value that flag has shown since reset. Once it is 0 it stays 0 until reset.
- R5: `run_fail` rises one cycle after a valid beat with any miscompared bit and stays high until reset, regardless of the loop count.
- R6: `loop_done` pulses are counted, saturating at LOOPS. While `run_fail` is low, `infinite_mode` is 0 and the count equals LOOPS, `run_pass` rises on the next cycle and then stays high. `run_pass` and `run_fail` are never both high: a later failure clears `run_pass` in the same cycle that `run_fail` rises.
- R7: While `infinite_mode` is 1, `run_pass` does not rise.
- R8: An idle counter restarts on every valid beat and otherwise counts up, saturating at WDOG_LIMIT. One cycle after the counter sits at WDOG_LIMIT while `run_pass` is low, `run_timeout` rises. It then stays high until reset and does not depend on data errors.
- R9: `rst` is synchronous and active high. After a reset cycle, all flags are 1, the verdicts are 0, and the loop and idle counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read beat valid strobe |
| rd_data | input | MEM_W*BEATS | Read word returned by memory |
| exp_data | input | MEM_W*BEATS | Expected word for the same beat |
| loop_done | input | 1 | One-cycle pulse at the end of each test loop |
| infinite_mode | input | 1 | 1 = run forever, pass never reported |
| bit_ok | output | MEM_W*BEATS | Live per-bit pass-not-fail flags |
| bit_ok_sticky | output | MEM_W*BEATS | Persistent per-bit pass-not-fail flags |
| run_pass | output | 1 | Run completed with no error |
| run_fail | output | 1 | A miscompare has been seen |
| run_timeout | output | 1 | Read traffic stalled past the watchdog limit |

## Verification
Every result is registered, so each result is due exactly one clock edge after the input cycle that causes it. The per-bit flags and `run_fail` follow the compared beat by one cycle. `run_pass` follows by one cycle the state in which the loop count reached LOOPS. `run_timeout` follows by one cycle the state in which the idle counter reached WDOG_LIMIT, so it is first seen WDOG_LIMIT+1 edges after the last valid beat. The bench keeps this timing by updating a behavioural model on the rising edge from the inputs held since the previous falling edge. It then compares all outputs against the model on the falling edge, before the next inputs are driven.

// File: rtl/pnfchk_pkg.sv
package pnfchk_pkg;

    // Overall verdict of a test run.
    typedef enum logic [1:0] {
        RUN_ACTIVE = 2'd0,
        RUN_PASSED = 2'd1,
        RUN_FAILED = 2'd2
    } run_state_e;

    typedef struct packed {
        logic pass;
        logic fail;
        logic timeout;
    } verdict_t;

    // Position of a data lane of a given beat inside the folded word.
    function automatic int flag_index(input int beat, input int lane, input int mem_w);
        return beat * mem_w + lane;
    endfunction

    // Next value of a saturating counter.
    function automatic int sat_inc(input int value, input int limit);
        return (value >= limit) ? limit : value + 1;
    endfunction

endpackage

// File: rtl/pnf_lane_bank.sv
module pnf_lane_bank #(
    parameter int MEM_W = 32,
    parameter int BEATS = 8,
    localparam int W = MEM_W * BEATS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic [W-1:0] rd_word,
    input  logic [W-1:0] exp_word,
    output logic [W-1:0] live_ok,
    output logic [W-1:0] sticky_ok,
    output logic         any_miss
);
    import pnfchk_pkg::*;

    logic [BEATS-1:0] beat_miss;

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        localparam int LO = flag_index(b, 0, MEM_W);
        logic [MEM_W-1:0] eq_lane;
        logic [MEM_W-1:0] live_d;

        always_comb begin
            eq_lane = ~(rd_word[LO +: MEM_W] ^ exp_word[LO +: MEM_W]);
            live_d  = valid ? eq_lane : '1;
        end

        assign beat_miss[b] = ~(&live_d);

        always_ff @(posedge clk) begin
            if (rst) begin
                live_ok[LO +: MEM_W]   <= '1;
                sticky_ok[LO +: MEM_W] <= '1;
            end else begin
                live_ok[LO +: MEM_W]   <= live_d;
                sticky_ok[LO +: MEM_W] <= sticky_ok[LO +: MEM_W] & live_d;
            end
        end
    end

    assign any_miss = |beat_miss;

endmodule

// File: rtl/run_verdict.sv
module run_verdict #(
    parameter int LOOPS = 4,
    localparam int CW = $clog2(LOOPS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_done,
    input  logic infinite_mode,
    input  logic miss,
    output logic pass,
    output logic fail
);
    import pnfchk_pkg::*;

    localparam logic [CW-1:0] LOOP_TARGET = CW'(LOOPS);

    run_state_e    state_q, state_d;
    logic [CW-1:0] loops_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loops_q <= '0;
        end else if (loop_done && loops_q != LOOP_TARGET) begin
            loops_q <= loops_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_ACTIVE: begin
                if (miss) begin
                    state_d = RUN_FAILED;
                end else if (!infinite_mode && loops_q == LOOP_TARGET) begin
                    state_d = RUN_PASSED;
                end
            end
            RUN_PASSED: begin
                if (miss) begin
                    state_d = RUN_FAILED;
                end
            end
            default: state_d = RUN_FAILED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RUN_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pass = (state_q == RUN_PASSED);
    assign fail = (state_q == RUN_FAILED);

endmodule

// File: rtl/idle_watchdog.sv
module idle_watchdog #(
    parameter int WDOG_LIMIT = 64,
    localparam int CW = $clog2(WDOG_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic beat_seen,
    input  logic finished,
    output logic expired
);
    localparam logic [CW-1:0] LIMIT = CW'(WDOG_LIMIT);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (beat_seen) begin
            idle_q <= '0;
        end else if (idle_q != LIMIT) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expired <= 1'b0;
        end else if (idle_q == LIMIT && !finished) begin
            expired <= 1'b1;
        end
    end

endmodule

// File: rtl/pnf_result_checker.sv
module pnf_result_checker #(
    parameter int MEM_W      = 32,
    parameter int BEATS      = 8,
    parameter int LOOPS      = 4,
    parameter int WDOG_LIMIT = 64,
    localparam int W = MEM_W * BEATS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_valid,
    input  logic [W-1:0] rd_data,
    input  logic [W-1:0] exp_data,
    input  logic         loop_done,
    input  logic         infinite_mode,
    output logic [W-1:0] bit_ok,
    output logic [W-1:0] bit_ok_sticky,
    output logic         run_pass,
    output logic         run_fail,
    output logic         run_timeout
);
    import pnfchk_pkg::*;

    logic     miss;
    verdict_t verdict;

    pnf_lane_bank #(.MEM_W(MEM_W), .BEATS(BEATS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .valid    (rd_valid),
        .rd_word  (rd_data),
        .exp_word (exp_data),
        .live_ok  (bit_ok),
        .sticky_ok(bit_ok_sticky),
        .any_miss (miss)
    );

    run_verdict #(.LOOPS(LOOPS)) u_verdict (
        .clk          (clk),
        .rst          (rst),
        .loop_done    (loop_done),
        .infinite_mode(infinite_mode),
        .miss         (miss),
        .pass         (verdict.pass),
        .fail         (verdict.fail)
    );

    idle_watchdog #(.WDOG_LIMIT(WDOG_LIMIT)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .beat_seen(rd_valid),
        .finished (verdict.pass),
        .expired  (verdict.timeout)
    );

    assign run_pass    = verdict.pass;
    assign run_fail    = verdict.fail;
    assign run_timeout = verdict.timeout;

endmodule

// File: rtl/pnf_checker_props.sv
module pnf_checker_props #(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_valid,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] exp_data,
    input logic         infinite_mode,
    input logic [W-1:0] bit_ok,
    input logic [W-1:0] bit_ok_sticky,
    input logic         run_pass,
    input logic         run_fail,
    input logic         run_timeout
);
    p_idle_all_high_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (bit_ok == {W{1'b1}}));

    p_match_all_high_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_data == exp_data) |=> (bit_ok == {W{1'b1}}));

    p_sticky_under_live_r4: assert property (@(posedge clk) disable iff (rst)
        ((bit_ok_sticky & ~bit_ok) == '0));

    p_sticky_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((bit_ok_sticky & ~$past(bit_ok_sticky)) == '0));

    p_fail_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_data != exp_data) |=> run_fail);

    p_fail_holds_r5: assert property (@(posedge clk) disable iff (rst)
        run_fail |=> run_fail);

    p_verdict_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(run_pass && run_fail));

    p_inf_no_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (infinite_mode && !run_pass) |=> !run_pass);

    p_timeout_holds_r8: assert property (@(posedge clk) disable iff (rst)
        run_timeout |=> run_timeout);

    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!run_pass && !run_fail && !run_timeout && bit_ok_sticky == {W{1'b1}}));
endmodule

bind pnf_result_checker pnf_checker_props #(.W(W)) u_props (
    .clk          (clk),
    .rst          (rst),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .exp_data     (exp_data),
    .infinite_mode(infinite_mode),
    .bit_ok       (bit_ok),
    .bit_ok_sticky(bit_ok_sticky),
    .run_pass     (run_pass),
    .run_fail     (run_fail),
    .run_timeout  (run_timeout)
);

// File: tb/pnf_result_checker_bench.sv
module pnf_result_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_W = 32;
    localparam int BEATS = 8;
    localparam int LOOPS = 4;
    localparam int WDOG  = 64;
    localparam int W     = MEM_W * BEATS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_valid = 1'b0;
    logic [W-1:0] rd_data = '0;
    logic [W-1:0] exp_data = '0;
    logic         loop_done = 1'b0;
    logic         infinite_mode = 1'b0;
    logic [W-1:0] bit_ok, bit_ok_sticky;
    logic         run_pass, run_fail, run_timeout;

    int n_checks = 0;
    int n_fail   = 0;

    // Behavioural model state
    logic [W-1:0] m_live, m_sticky;
    logic         m_pass, m_fail, m_tmo;
    int           m_loops, m_idle;

    always #(CLK_PERIOD/2) clk = ~clk;

    pnf_result_checker #(.MEM_W(MEM_W), .BEATS(BEATS), .LOOPS(LOOPS), .WDOG_LIMIT(WDOG)) u_pnf_result_checker (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_data(rd_data), .exp_data(exp_data),
        .loop_done(loop_done), .infinite_mode(infinite_mode), .bit_ok(bit_ok),
        .bit_ok_sticky(bit_ok_sticky), .run_pass(run_pass), .run_fail(run_fail),
        .run_timeout(run_timeout)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model update: uses inputs held since the previous falling edge.
    always @(posedge clk) begin
        if (rst) begin
            m_live = '1; m_sticky = '1; m_pass = 0; m_fail = 0; m_tmo = 0;
            m_loops = 0; m_idle = 0;
        end else begin
            logic [W-1:0] nl;
            logic         bad;
            logic         np;
            nl  = rd_valid ? ~(rd_data ^ exp_data) : '1;
            bad = (nl != '1);
            if (!m_pass && m_idle == WDOG) m_tmo = 1;
            np = m_pass || (!infinite_mode && m_loops == LOOPS);
            m_fail = m_fail || bad;
            m_pass = np && !m_fail;
            m_live = nl;
            m_sticky = m_sticky & nl;
            if (loop_done && m_loops < LOOPS) m_loops++;
            m_idle = rd_valid ? 0 : (m_idle < WDOG ? m_idle + 1 : WDOG);
        end
    end

    // Compare every cycle, away from the active edge.
    bit model_ready = 0;
    always @(negedge clk) begin
        if (model_ready) begin
            check(bit_ok == m_live, "R2 live flags", bit_ok, m_live);
            check(bit_ok_sticky == m_sticky, "R4 sticky flags", bit_ok_sticky, m_sticky);
            check(run_fail == m_fail, "R5 fail", W'(run_fail), W'(m_fail));
            check(run_pass == m_pass, "R6 pass", W'(run_pass), W'(m_pass));
            check(run_timeout == m_tmo, "R8 timeout", W'(run_timeout), W'(m_tmo));
        end
    end

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] v;
        for (int i = 0; i < BEATS; i++) v[i*MEM_W +: MEM_W] = $urandom;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; rd_valid = 0; loop_done = 0;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic beat(input logic [W-1:0] flip, input bit loop);
        @(negedge clk);
        rd_valid = 1; rd_data = rand_word(); exp_data = rd_data ^ flip; loop_done = loop;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_valid = 0; loop_done = 0; rd_data = rand_word(); exp_data = rand_word();
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 0; // model sees reset on first edges
        do_reset();
        model_ready = 1;
        // R9: reset state
        @(negedge clk);
        check(bit_ok == '1 && bit_ok_sticky == '1, "R9 flags after reset", bit_ok, '1);
        check(!run_pass && !run_fail && !run_timeout, "R9 verdicts after reset",
              W'({run_pass, run_fail, run_timeout}), '0);

        // Finite run with clean traffic, R6
        for (int i = 0; i < 6; i++) beat('0, 0);
        idle(1);
        @(negedge clk);
        check(bit_ok == '1, "R3 idle with garbage data", bit_ok, '1);
        for (int i = 0; i < LOOPS; i++) begin beat('0, 1); beat('0, 0); end
        idle(2);
        check(run_pass && !run_fail, "R6 pass after loops", W'(run_pass), W'(1));
        // Long idle after pass: no timeout (R8)
        idle(WDOG + 4);
        check(!run_timeout, "R8 no timeout after pass", W'(run_timeout), '0);
        // Later failure clears pass (R6)
        beat(W'(1) << 5, 0);
        idle(1);
        check(run_fail && !run_pass, "R6 fail overrides pass", W'({run_pass, run_fail}), W'(2'b01));

        // Infinite mode, mapping, sticky, timeout
        do_reset();
        infinite_mode = 1;
        for (int i = 0; i < LOOPS + 3; i++) beat('0, 1);
        idle(2);
        check(!run_pass, "R7 infinite mode never passes", W'(run_pass), '0);
        beat(W'(1) << pnfchk_pkg::flag_index(2, 0, MEM_W), 0);
        idle(1);
        check(bit_ok == ~(W'(1) << 64), "R1 flag 64 is beat 2 lane 0", bit_ok, ~(W'(1) << 64));
        check(run_fail, "R5 fail after miscompare", W'(run_fail), W'(1));
        @(negedge clk);
        check(bit_ok == '1, "R2 live flag recovers", bit_ok, '1);
        check(bit_ok_sticky == ~(W'(1) << 64), "R4 sticky stays low", bit_ok_sticky, ~(W'(1) << 64));
        idle(WDOG + 2);
        check(run_timeout, "R8 timeout after stall", W'(run_timeout), W'(1));

        // Finite with early error: no pass; last-beat lane mapping
        do_reset();
        infinite_mode = 0;
        beat(W'(1) << (W - 1), 0);
        for (int i = 0; i < LOOPS; i++) beat('0, 1);
        idle(3);
        check(!run_pass && run_fail, "R6 no pass after error", W'(run_pass), '0);
        check(bit_ok_sticky == ~(W'(1) << (W - 1)), "R1 top flag is last beat top lane",
              bit_ok_sticky, ~(W'(1) << (W - 1)));

        // Timeout before pass with no traffic at all
        do_reset();
        idle(WDOG);
        check(!run_timeout, "R8 no timeout at limit edge", W'(run_timeout), '0);
        idle(1);
        check(run_timeout, "R8 timeout one edge later", W'(run_timeout), W'(1));
        idle(2);
        finish_run();
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule